// File: doc/BRIEF.md
# MIDI Stream to Quadlet Packer

This block turns an outgoing MIDI byte stream into 32-bit transaction words. Bytes arrive one per cycle on a valid/ready input and collect in a lookahead of three bytes. For each word the block decides how many of the buffered bytes to take. It then offers the word, together with that byte count, on a valid/ready output. The low byte of the word is a header made of the port number and the count. The message bytes follow in arrival order.

One channel can serve several MIDI ports. A plain `port_sel` input names the port that the buffered bytes belong to. The block keeps a system-exclusive flag for each port, so the handling of a sysex body depends on that port's own history. Outside sysex, a channel or system message is held back until it is complete in the lookahead, and each word then carries exactly one message. Inside sysex, body bytes are packed as densely as they arrive. The end code F7 is always split off into a word of its own, marked by a header nibble of 0xF.

Back-pressure rules. An input byte is taken on a cycle with `in_valid` and `in_ready` both high. `in_ready` is low whenever the lookahead is full or a word is being offered. Once `out_valid` rises, the word and the count stay fixed until a cycle with `out_ready` high. The consumed bytes leave the lookahead only on that accepting cycle. `port_sel` must stay constant from the first byte of a word until that word is accepted.

Top module: `midi_quad_packer`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) empties the lookahead, drops `out_valid` and clears the sysex flag of every port. An F7 sent after reset, even into a port that was inside sysex, is packed as an ordinary byte with count 1.
- R2: Word layout. Bits 7:4 hold the port number and bits 3:0 the count. The first, second and third message bytes sit in bits 15:8, 23:16 and 31:24. Payload positions past the count are zero. `out_count` equals the number of bytes taken and is never 0 while `out_valid` is high.
- R3: While `out_valid` is high and `out_ready` is low, the word and the count stay unchanged in the next cycle. `in_ready` is low while `out_valid` is high. Bytes are removed from the lookahead only on the accepting cycle.
- R4: Outside sysex, the statuses F6, F8, FA, FB, FC, FE and FF each go alone in a word with count 1, even when more bytes follow.
- R5: Outside sysex, F1, F3 and status bytes 0xC0–0xDF form 2-byte messages: one word with count 2, offered only once both bytes are buffered.
- R6: Outside sysex, F2 and status bytes 0x80–0xBF and 0xE0–0xEF form 3-byte messages. No word is offered before all three bytes are buffered.
- R7: Outside sysex, a first byte that is a data byte (below 0x80) or one of F4, F5, F7, F9, FD has no defined length. Bytes keep being gathered while `in_valid` stays high. The word goes out when three are buffered or when the input goes idle, carrying every buffered byte.
- R8: Outside sysex, a first byte of F0 sets the selected port's sysex flag when its word is accepted. That word carries F0 and the bytes after it, up to three, stopping before any F7.
- R9: In sysex with a first byte other than F7, an F7 in the second or third lookahead position ends gathering. The word takes only the bytes before the F7 (count 1 or 2). With no F7 present, gathering follows the R7 rule.
- R10: In sysex, a first byte of F7 is sent alone in a word: payload F7, header bits 3:0 = 0xF, `out_count` = 1. Acceptance clears that port's flag.
- R11: Sysex flags are kept per port. Words on one port never change another port's flag.
- R12: With an empty lookahead, `out_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| port_sel | input | PW = max(1, clog2(NUM_PORTS)) | Port that the buffered bytes belong to |
| in_valid | input | 1 | Input byte offered |
| in_data | input | 8 | Input MIDI byte |
| in_ready | output | 1 | Input byte taken when high together with in_valid |
| out_valid | output | 1 | Packed word offered |
| out_ready | input | 1 | Consumer accepts the offered word |
| out_word | output | 32 | Header byte plus up to three message bytes |
| out_count | output | 2 | Number of bytes taken from the lookahead for this word |

## Verification
A wrong per-port sysex flag shows up on the next word of that port. An F7 comes out with a count nibble instead of 0xF, or the reverse, or a sysex body word stops at the wrong byte. A lookahead that shifts wrongly shows up as a misordered or repeated payload byte in the word after the next acceptance. A wrong completeness decision changes the cycle in which `out_valid` rises, and that is visible the same cycle. The bench compares `out_valid`, `in_ready`, `out_word` and `out_count` against a queue-based model on every clock, under stalls on both sides. It also checks literal word lists for each message class.

// File: rtl/midi_qp_pkg.sv
package midi_qp_pkg;

  localparam int WORD_BYTES = 3;
  localparam int CNT_W      = $clog2(WORD_BYTES + 1);
  localparam logic [7:0] SX_OPEN  = 8'hF0;
  localparam logic [7:0] SX_CLOSE = 8'hF7;
  localparam logic [3:0] END_NIBBLE = 4'hF;

  typedef struct packed {
    logic [CNT_W-1:0] take;
    logic             complete;
    logic             end_mark;
    logic             open_sx;
  } pack_plan_t;

  // Message length implied by a first byte; 0 means no defined length.
  function automatic logic [CNT_W-1:0] status_len(input logic [7:0] s);
    logic [CNT_W-1:0] n;
    n = '0;
    if (s[7]) begin
      if (s[7:4] == 4'hF) begin
        case (s[3:0])
          4'h6, 4'h8, 4'hA, 4'hB, 4'hC, 4'hE, 4'hF: n = CNT_W'(1);
          4'h1, 4'h3:                               n = CNT_W'(2);
          4'h2:                                     n = CNT_W'(3);
          default:                                  n = '0;
        endcase
      end else if (s[7:4] == 4'hC || s[7:4] == 4'hD) begin
        n = CNT_W'(2);
      end else begin
        n = CNT_W'(3);
      end
    end
    return n;
  endfunction

endpackage

// File: rtl/mqp_lookahead.sv
module mqp_lookahead #(
  parameter int DEPTH = 3,
  parameter int DW    = 8,
  localparam int FW   = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      push,
  input  logic [DW-1:0]             push_data,
  input  logic                      pop,
  input  logic [FW-1:0]             pop_n,
  output logic [DEPTH-1:0][DW-1:0]  slots_o,
  output logic [FW-1:0]             fill_o
);

  logic [DEPTH-1:0][DW-1:0] slot_q, slot_d;
  logic [FW-1:0]            fill_q, fill_d;

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      slot_d[i] = slot_q[i];
      if (pop) begin
        slot_d[i] = '0;
        for (int j = 0; j < DEPTH; j++) begin
          if (j == i + int'(pop_n)) slot_d[i] = slot_q[j];
        end
      end else if (push && int'(fill_q) == i) begin
        slot_d[i] = push_data;
      end
    end
    if (pop)       fill_d = fill_q - pop_n;
    else if (push) fill_d = fill_q + FW'(1);
    else           fill_d = fill_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot_q <= '0;
      fill_q <= '0;
    end else begin
      slot_q <= slot_d;
      fill_q <= fill_d;
    end
  end

  assign slots_o = slot_q;
  assign fill_o  = fill_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> int'(fill_q) < DEPTH);

  assert_pop_within_fill_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (pop_n != '0) && (pop_n <= fill_q));

  assert_no_push_on_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/mqp_decide.sv
module mqp_decide
  import midi_qp_pkg::*;
(
  input  logic [WORD_BYTES-1:0][7:0] slots,
  input  logic [CNT_W-1:0]           fill,
  input  logic                       in_sx,
  input  logic                       more_coming,
  output pack_plan_t                 plan
);

  logic [CNT_W-1:0] msg_len;
  logic             close_at1, close_at2, stream_done;

  always_comb begin
    msg_len     = status_len(slots[0]);
    close_at1   = (fill >= CNT_W'(2)) && (slots[1] == SX_CLOSE);
    close_at2   = (fill == CNT_W'(3)) && (slots[2] == SX_CLOSE);
    stream_done = (fill == CNT_W'(WORD_BYTES)) || !more_coming;

    plan = '0;
    if (in_sx && slots[0] == SX_CLOSE) begin
      plan.take     = CNT_W'(1);
      plan.complete = 1'b1;
      plan.end_mark = 1'b1;
    end else if (in_sx || slots[0] == SX_OPEN) begin
      plan.open_sx = !in_sx;
      if (close_at1) begin
        plan.take     = CNT_W'(1);
        plan.complete = 1'b1;
      end else if (close_at2) begin
        plan.take     = CNT_W'(2);
        plan.complete = 1'b1;
      end else begin
        plan.take     = fill;
        plan.complete = stream_done;
      end
    end else if (msg_len != '0) begin
      plan.take     = msg_len;
      plan.complete = (fill >= msg_len);
    end else begin
      plan.take     = fill;
      plan.complete = stream_done;
    end
  end

endmodule

// File: rtl/mqp_sx_flags.sv
module mqp_sx_flags #(
  parameter int NUM_PORTS = 4,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] sel,
  input  logic          set,
  input  logic          clr,
  output logic          cur
);

  logic [NUM_PORTS-1:0] flag_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[p] <= 1'b0;
      end else if (sel == PW'(p)) begin
        if (set)      flag_q[p] <= 1'b1;
        else if (clr) flag_q[p] <= 1'b0;
      end
    end

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (set && sel == PW'(p)) |=> flag_q[p]);

    assert_flag_clr_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && sel == PW'(p)) |=> !flag_q[p]);

    assert_port_isolation_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel != PW'(p)) |=> $stable(flag_q[p]));
  end

  always_comb begin
    cur = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel == PW'(p)) cur = flag_q[p];
    end
  end

endmodule

// File: rtl/midi_quad_packer.sv
module midi_quad_packer
  import midi_qp_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  localparam int PW = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PW-1:0]    port_sel,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [31:0]      out_word,
  output logic [CNT_W-1:0] out_count
);

  logic [WORD_BYTES-1:0][7:0] slots;
  logic [WORD_BYTES-1:0][7:0] payload;
  logic [CNT_W-1:0]           fill;
  logic                       sx_cur, offered_q, accept;
  pack_plan_t                 plan;
  logic [3:0]                 port_nib, cnt_nib;

  mqp_lookahead #(.DEPTH(WORD_BYTES), .DW(8)) u_look (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (in_valid && in_ready),
    .push_data (in_data),
    .pop       (accept),
    .pop_n     (plan.take),
    .slots_o   (slots),
    .fill_o    (fill)
  );

  mqp_sx_flags #(.NUM_PORTS(NUM_PORTS)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .sel   (port_sel),
    .set   (accept && plan.open_sx),
    .clr   (accept && plan.end_mark),
    .cur   (sx_cur)
  );

  mqp_decide u_decide (
    .slots       (slots),
    .fill        (fill),
    .in_sx       (sx_cur),
    .more_coming (in_valid),
    .plan        (plan)
  );

  // Once offered, the word stays offered until taken.
  always_ff @(posedge clk) begin
    if (!rst_n) offered_q <= 1'b0;
    else        offered_q <= out_valid && !out_ready;
  end

  assign out_valid = (fill != '0) && (offered_q || plan.complete);
  assign in_ready  = (fill != CNT_W'(WORD_BYTES)) && !out_valid;
  assign accept    = out_valid && out_ready;

  for (genvar k = 0; k < WORD_BYTES; k++) begin : g_pay
    assign payload[k] = (int'(plan.take) > k) ? slots[k] : 8'h00;
  end

  assign port_nib  = 4'(port_sel);
  assign cnt_nib   = plan.end_mark ? END_NIBBLE : 4'(plan.take);
  assign out_word  = {payload[2], payload[1], payload[0], port_nib, cnt_nib};
  assign out_count = plan.take;

  assert_hold_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_count)));

  assert_no_intake_while_offering_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  assert_count_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_count != '0));

  assert_end_word_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_word[3:0] == END_NIBBLE) |->
      (out_word[15:8] == SX_CLOSE && out_word[31:16] == 16'h0 && out_count == CNT_W'(1)));

endmodule

// File: tb/test_midi_quad_packer.sv
module test_midi_quad_packer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  port_sel;
  logic        in_valid;
  logic [7:0]  in_data;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready;
  logic [31:0] out_word;
  logic [1:0]  out_count;

  always #10 clk = ~clk;

  midi_quad_packer #(.NUM_PORTS(4)) i_midi_quad_packer (
    .clk       (clk),
    .rst_n     (rst_n),
    .port_sel  (port_sel),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_word  (out_word),
    .out_count (out_count)
  );

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;
  string cur_tag = "R1";

  logic [7:0]  src_q[$];
  logic [7:0]  mq[$];
  logic [31:0] got_q[$];
  logic [31:0] exp_q[$];
  bit          msx[4];
  bit          mcommit;
  bit          hold;

  bit          e_ov, e_ir, e_end, e_set;
  int          e_take;
  logic [31:0] e_word;

  function automatic int len_of(input logic [7:0] b);
    if (b < 8'h80) return 0;
    if (b >= 8'hF0) begin
      if (b == 8'hF2) return 3;
      if (b == 8'hF1 || b == 8'hF3) return 2;
      if (b == 8'hF6 || b == 8'hF8 || b == 8'hFA || b == 8'hFB ||
          b == 8'hFC || b == 8'hFE || b == 8'hFF) return 1;
      return 0;
    end
    if (b >= 8'hC0 && b < 8'hE0) return 2;
    return 3;
  endfunction

  task automatic model_eval(input bit iv);
    int n;
    bit done;
    n = mq.size();
    e_take = 0; e_end = 0; e_set = 0; done = 0;
    if (n > 0) begin
      if (msx[port_sel] && mq[0] == 8'hF7) begin
        e_take = 1; e_end = 1; done = 1;
      end else if (msx[port_sel] || mq[0] == 8'hF0) begin
        e_set = !msx[port_sel];
        e_take = n;
        done = (n == 3) || !iv;
        for (int k = n - 1; k >= 1; k--) begin
          if (mq[k] == 8'hF7) begin e_take = k; done = 1; end
        end
      end else if (len_of(mq[0]) > 0) begin
        e_take = len_of(mq[0]);
        done = (n >= e_take);
      end else begin
        e_take = n;
        done = (n == 3) || !iv;
      end
    end
    e_ov = (n > 0) && (mcommit || done);
    e_ir = (n < 3) && !e_ov;
    e_word = {24'h0, 2'b00, port_sel, 4'h0};
    e_word[3:0] = e_end ? 4'hF : 4'(e_take);
    for (int k = 0; k < 3; k++) begin
      if (k < e_take && k < n) e_word[8*k+8 +: 8] = mq[k];
    end
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input int stall, input int gap);
    bit present;
    @(negedge clk);
    present = (src_q.size() > 0) && (gap == 0 || hold || (cyc % 2 == 0));
    in_valid  = present;
    in_data   = present ? src_q[0] : 8'h00;
    out_ready = (stall == 0) || (cyc % 3 == 2);
    #1;
    model_eval(present);
    check({cur_tag, " out_valid"}, 32'(out_valid), 32'(e_ov));
    check({cur_tag, " in_ready"}, 32'(in_ready), 32'(e_ir));
    if (e_ov) begin
      check({cur_tag, " word"}, out_word, e_word);
      check({cur_tag, " count"}, 32'(out_count), 32'(e_take));
    end
    if (out_valid && out_ready) got_q.push_back(out_word);
    @(posedge clk);
    if (present && e_ir) begin
      mq.push_back(in_data);
      void'(src_q.pop_front());
      hold = 0;
    end else begin
      hold = present;
    end
    if (e_ov && out_ready) begin
      for (int k = 0; k < e_take; k++) void'(mq.pop_front());
      if (e_set) msx[port_sel] = 1;
      if (e_end) msx[port_sel] = 0;
      mcommit = 0;
    end else begin
      mcommit = e_ov;
    end
    cyc++;
  endtask

  task automatic run_seq(input int port, input int stall, input int gap);
    int guard;
    @(negedge clk);
    port_sel = 2'(port);
    got_q.delete();
    guard = 0;
    while ((src_q.size() > 0 || mq.size() > 0) && guard < 400) begin
      step(stall, gap);
      guard++;
    end
    for (int k = 0; k < 3; k++) step(stall, gap);
  endtask

  task automatic expect_words(input string tag);
    check({tag, " word count"}, 32'(got_q.size()), 32'(exp_q.size()));
    for (int k = 0; k < exp_q.size(); k++) begin
      check({tag, " word"}, (k < got_q.size()) ? got_q[k] : 32'hDEAD_BEEF, exp_q[k]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = 8'h00; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check("R1 out_valid in reset", 32'(out_valid), 32'h0);
    rst_n = 1'b1;
    mq.delete(); src_q.delete();
    for (int p = 0; p < 4; p++) msx[p] = 0;
    mcommit = 0; hold = 0;
    @(negedge clk);
    #1;
    check("R1 out_valid after reset", 32'(out_valid), 32'h0);
    check("R1 in_ready after reset", 32'(in_ready), 32'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    port_sel = 2'd0;
    do_reset();

    // R12: empty lookahead stays silent
    cur_tag = "R12";
    for (int k = 0; k < 4; k++) step(0, 0);
    check("R12 idle out_valid", 32'(out_valid), 32'h0);

    // R6 / R2: three-byte channel message
    cur_tag = "R6";
    src_q = '{8'h90, 8'h3C, 8'h40};
    run_seq(1, 0, 0);
    exp_q = '{32'h403C9013};
    expect_words("R6");

    // R5 / R2: two-byte message, top byte zero
    cur_tag = "R5";
    src_q = '{8'hC5, 8'h07};
    run_seq(2, 0, 0);
    exp_q = '{32'h0007C522};
    expect_words("R5");

    // R4: one-byte statuses never bundled
    cur_tag = "R4";
    src_q = '{8'hF8, 8'hFE};
    run_seq(0, 0, 0);
    exp_q = '{32'h0000F801, 32'h0000FE01};
    expect_words("R4");

    // R7: data and undefined bytes gathered
    cur_tag = "R7";
    src_q = '{8'h3C, 8'h40};
    run_seq(0, 0, 0);
    exp_q = '{32'h00403C02};
    expect_words("R7");
    src_q = '{8'h11, 8'h22, 8'h33, 8'h44};
    run_seq(0, 0, 0);
    exp_q = '{32'h33221103, 32'h00004401};
    expect_words("R7");
    src_q = '{8'hF4, 8'h12};
    run_seq(0, 0, 0);
    exp_q = '{32'h0012F402};
    expect_words("R7");

    // R8 / R9 / R10: full sysex on port 3, then F7 outside sysex
    cur_tag = "R10";
    src_q = '{8'hF0, 8'h01, 8'h02, 8'h03, 8'h04, 8'hF7, 8'hF7};
    run_seq(3, 0, 0);
    exp_q = '{32'h0201F033, 32'h00040332, 32'h0000F73F, 32'h0000F731};
    expect_words("R10");

    // R8: opener word stops before F7
    cur_tag = "R8";
    src_q = '{8'hF0, 8'h05, 8'hF7};
    run_seq(3, 0, 0);
    exp_q = '{32'h0005F032, 32'h0000F73F};
    expect_words("R8");
    src_q = '{8'hF0, 8'hF7};
    run_seq(3, 0, 0);
    exp_q = '{32'h0000F031, 32'h0000F73F};
    expect_words("R8");

    // R9: F7 in second position inside sysex
    cur_tag = "R9";
    src_q = '{8'hF0, 8'h11, 8'h22, 8'h33, 8'hF7};
    run_seq(0, 0, 0);
    exp_q = '{32'h2211F003, 32'h00003301, 32'h0000F70F};
    expect_words("R9");

    // R11: per-port flags
    cur_tag = "R11";
    src_q = '{8'hF0, 8'h01};
    run_seq(1, 0, 0);
    src_q = '{8'hF7};
    run_seq(2, 0, 0);
    exp_q = '{32'h0000F721};
    expect_words("R11");
    src_q = '{8'hF7};
    run_seq(1, 0, 0);
    exp_q = '{32'h0000F71F};
    expect_words("R11");

    // R3: stalls on both sides
    cur_tag = "R3";
    src_q = '{8'h90, 8'h3C, 8'h40, 8'hB0, 8'h07, 8'h7F};
    run_seq(1, 1, 1);
    exp_q = '{32'h403C9013, 32'h7F07B013};
    expect_words("R3");

    // R1: reset clears a pending sysex flag
    cur_tag = "R1";
    src_q = '{8'hF0, 8'h01};
    run_seq(0, 0, 0);
    exp_q = '{32'h0001F002};
    expect_words("R1");
    do_reset();
    src_q = '{8'hF7};
    run_seq(0, 0, 0);
    exp_q = '{32'h0000F701};
    expect_words("R1");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule